// File: doc/BRIEF.md
# Paged receive ring buffer writer

This block places incoming Ethernet frames, which have already passed address filtering, into a circular region of local packet memory. The memory is split into 256-byte pages. Four page registers describe the ring: the first page, the page one past the last page, a boundary page that marks how far the consumer has read, and the page where the next frame will be written. Each stored frame takes a whole number of pages. It begins with a 4-byte header that gives its status, the page of the frame that follows, and its stored length.

Frames arrive as a byte stream with start and end markers under a valid/ready handshake. When a frame starts, the block decides whether to store it. The frame is refused when the stop command is set, when the ring is wrongly configured, or when free space is below one maximum frame. An accepted frame is written from the fifth byte of its first page onward and wraps from the end of the ring back to its first page. A short frame is padded with zeros. After the last data byte the header is written, the current page moves on, and a sticky receive interrupt flag is raised. The stream is stalled from the end of a frame until that commit is done, so only one frame is in flight at a time.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the current page and every other ring register read zero, the interrupt flag is low, rx_ready is high and no memory write is issued.
- R2: A frame that starts while stop_cmd is high is consumed with no memory write, and the current page and interrupt flag are unchanged.
- R3: A frame is refused in the same way when the stop page is less than or equal to the start page.
- R4: Free bytes are 256 × (boundary − current) when current < boundary, and otherwise 256 × ((stop − start) − (current − boundary)). A frame is refused when this is below 1518.
- R5: A frame shorter than 60 bytes is extended with zero bytes to 60 bytes. A frame of 60 bytes or more gets no padding.
- R6: Data bytes, then pad bytes, are written to consecutive addresses starting at current page × 256 + 4. When the address reaches stop page × 256 it continues at start page × 256.
- R7: After the data, four header bytes are written to current page × 256 + 0..3, in this order: status, next page, stored length low byte, stored length high byte. The stored length is the padded frame size + 4.
- R8: The status byte is 0x01, or 0x21 when bit 0 of the first frame byte is set.
- R9: The next page is the current page plus ceil((stored length + 4) / 256). When that sum is at or above the stop page, (stop − start) is subtracted. The current page takes this value as the last header byte is written.
- R10: The interrupt flag goes high at the commit of every stored frame. It stays high until irq_clr is asserted, and a commit in the same cycle as irq_clr wins.
- R11: rx_ready is low from the cycle after an accepted frame's last byte until its header is committed. A byte without rx_sof presented while no frame is open is ignored.
- R12: cfg_sel selects the register written by cfg_we: 0 start, 1 stop, 2 boundary, 3 current. Start and stop writes above MEM_END_PG are ignored, and boundary and current writes at or above MEM_END_PG are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Ring register write strobe |
| cfg_sel | input | 2 | Ring register select (0 start, 1 stop, 2 boundary, 3 current) |
| cfg_wdata | input | PG_W | Page number to write |
| stop_cmd | input | 1 | Receiver stopped; frames are refused |
| irq_clr | input | 1 | Clears the receive interrupt flag |
| rx_valid | input | 1 | Frame byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_ready | output | 1 | Block can take a byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PG_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| cur_page | output | PG_W | Current page register |
| irq_rx | output | 1 | Sticky receive interrupt flag |

## Verification
The assertions assume that the ring registers do not change while a frame is in flight. They also assume the registers are consistent, with the start page at or below both the current and boundary pages and both of those below the stop page. Only under those conditions is every write address known to stay below the stop page. They further assume that every frame fits in the room found at its start and is framed with one start byte and one end byte. The stimulus writes the ring registers only between frames, keeps frames at or below 300 bytes, and sets every page value to satisfy those orderings.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int PAGE_SHIFT = 8;
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STOP  = 2'd1;
  localparam logic [1:0] SEL_BND   = 2'd2;
  localparam logic [1:0] SEL_CUR   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_PAD,
    ST_HDR
  } wr_state_t;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int PG_W       = 8,
  parameter int MEM_END_PG = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PG_W-1:0] cfg_wdata,
  input  logic            commit,
  input  logic [PG_W-1:0] next_pg,
  input  logic            irq_clr,
  output logic [PG_W-1:0] start_pg,
  output logic [PG_W-1:0] stop_pg,
  output logic [PG_W-1:0] bnd_pg,
  output logic [PG_W-1:0] cur_pg,
  output logic            irq_rx
);
  logic [PG_W-1:0] start_d, stop_d, bnd_d, cur_d;
  logic            irq_d;
  logic            wr_edge_ok, wr_in_ok;

  assign wr_edge_ok = int'(cfg_wdata) <= MEM_END_PG;
  assign wr_in_ok   = int'(cfg_wdata) <  MEM_END_PG;

  always_comb begin
    start_d = start_pg;
    stop_d  = stop_pg;
    bnd_d   = bnd_pg;
    cur_d   = cur_pg;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_START: if (wr_edge_ok) start_d = cfg_wdata;
        SEL_STOP:  if (wr_edge_ok) stop_d  = cfg_wdata;
        SEL_BND:   if (wr_in_ok)   bnd_d   = cfg_wdata;
        SEL_CUR:   if (wr_in_ok)   cur_d   = cfg_wdata;
        default: ;
      endcase
    end
    if (commit) cur_d = next_pg;
    if (commit)       irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pg <= '0;
      stop_pg  <= '0;
      bnd_pg   <= '0;
      cur_pg   <= '0;
      irq_rx   <= 1'b0;
    end else begin
      start_pg <= start_d;
      stop_pg  <= stop_d;
      bnd_pg   <= bnd_d;
      cur_pg   <= cur_d;
      irq_rx   <= irq_d;
    end
  end

  // R10: a commit always leaves the flag set, even against a clear
  a_r10_irq_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq_rx);
endmodule

// File: rtl/rxr_ring_math.sv
module rxr_ring_math
  import rxr_pkg::*;
#(
  parameter int PG_W       = 8,
  parameter int LEN_W      = 16,
  parameter int MEM_END_PG = 128,
  parameter int MAX_FRAME  = 1514
) (
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [PG_W-1:0]  bnd_pg,
  input  logic [PG_W-1:0]  cur_pg,
  input  logic [PG_W-1:0]  base_pg,
  input  logic [LEN_W-1:0] byte_cnt,
  output logic             room_ok,
  output logic [PG_W-1:0]  base_sel,
  output logic [PG_W-1:0]  next_pg
);
  localparam int SUM_W = PG_W + 2;

  int               avail_b;
  logic [SUM_W-1:0] used_pg, sum_pg, stop_ext, span_ext;

  always_comb begin
    if (cur_pg < bnd_pg)
      avail_b = (int'(bnd_pg) - int'(cur_pg)) * PAGE_BYTES;
    else
      avail_b = ((int'(stop_pg) - int'(start_pg)) - (int'(cur_pg) - int'(bnd_pg))) * PAGE_BYTES;
  end

  assign room_ok  = (stop_pg > start_pg) && (avail_b >= MAX_FRAME + 4);
  assign base_sel = (int'(cur_pg) >= MEM_END_PG) ? start_pg : cur_pg;

  // pages taken: header, data and four trailing bytes, rounded up
  assign used_pg  = SUM_W'((32'(byte_cnt) + 32'(8 + PAGE_BYTES - 1)) / 32'(PAGE_BYTES));
  assign sum_pg   = SUM_W'(base_pg) + used_pg;
  assign stop_ext = SUM_W'(stop_pg);
  assign span_ext = SUM_W'(stop_pg) - SUM_W'(start_pg);
  assign next_pg  = PG_W'((sum_pg >= stop_ext) ? (sum_pg - span_ext) : sum_pg);
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
  import rxr_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 60
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic                       rx_sof,
  input  logic                       rx_eof,
  input  logic [7:0]                 rx_data,
  output logic                       rx_ready,
  input  logic                       stop_cmd,
  input  logic                       room_ok,
  input  logic [PG_W-1:0]            base_sel,
  input  logic [PG_W-1:0]            start_pg,
  input  logic [PG_W-1:0]            stop_pg,
  input  logic [PG_W-1:0]            next_pg,
  output logic [PG_W-1:0]            base_pg,
  output logic [LEN_W-1:0]           byte_cnt,
  output logic                       commit,
  output logic                       mem_we,
  output logic [PG_W+PAGE_SHIFT-1:0] mem_addr,
  output logic [7:0]                 mem_wdata
);
  localparam int ADDR_W = PG_W + PAGE_SHIFT;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  wr_state_t         state_q, state_d;
  logic [PG_W-1:0]   base_d;
  logic [ADDR_W-1:0] daddr_q, daddr_d, addr_d;
  logic [LEN_W-1:0]  cnt_d, cnt_inc;
  logic              grp_q, grp_d, we_d;
  logic [1:0]        hidx_q, hidx_d;
  logic [7:0]        wd_d, status_b;
  logic [15:0]       total_len;
  logic              beat;

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [PG_W-1:0]   sp,
    input logic [PG_W-1:0]   st
  );
    logic [ADDR_W-1:0] n;
    n = a + ADDR_W'(1);
    if (n == {sp, {PAGE_SHIFT{1'b0}}}) n = {st, {PAGE_SHIFT{1'b0}}};
    return n;
  endfunction

  assign rx_ready  = (state_q == ST_IDLE) || (state_q == ST_RECV) || (state_q == ST_DROP);
  assign beat      = rx_valid && rx_ready;
  assign cnt_inc   = byte_cnt + LEN_W'(1);
  assign total_len = 16'(byte_cnt) + 16'd4;
  assign status_b  = {2'b00, grp_q, 4'b0000, 1'b1};

  always_comb begin
    state_d = state_q;
    base_d  = base_pg;
    daddr_d = daddr_q;
    cnt_d   = byte_cnt;
    grp_d   = grp_q;
    hidx_d  = hidx_q;
    we_d    = 1'b0;
    addr_d  = mem_addr;
    wd_d    = mem_wdata;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (beat && rx_sof) begin
          if (stop_cmd || !room_ok) begin
            if (!rx_eof) state_d = ST_DROP;
          end else begin
            base_d  = base_sel;
            we_d    = 1'b1;
            addr_d  = {base_sel, PAGE_SHIFT'(4)};
            wd_d    = rx_data;
            grp_d   = rx_data[0];
            cnt_d   = LEN_W'(1);
            hidx_d  = 2'd0;
            daddr_d = step_addr({base_sel, PAGE_SHIFT'(4)}, stop_pg, start_pg);
            if (!rx_eof)                    state_d = ST_RECV;
            else if (LEN_W'(1) < MIN_LEN)   state_d = ST_PAD;
            else                            state_d = ST_HDR;
          end
        end
      end
      ST_RECV: begin
        if (beat) begin
          we_d    = 1'b1;
          addr_d  = daddr_q;
          wd_d    = rx_data;
          cnt_d   = cnt_inc;
          daddr_d = step_addr(daddr_q, stop_pg, start_pg);
          if (rx_eof) state_d = (cnt_inc < MIN_LEN) ? ST_PAD : ST_HDR;
        end
      end
      ST_DROP: begin
        if (beat && rx_eof) state_d = ST_IDLE;
      end
      ST_PAD: begin
        we_d    = 1'b1;
        addr_d  = daddr_q;
        wd_d    = 8'h00;
        cnt_d   = cnt_inc;
        daddr_d = step_addr(daddr_q, stop_pg, start_pg);
        if (cnt_inc >= MIN_LEN) state_d = ST_HDR;
      end
      ST_HDR: begin
        we_d   = 1'b1;
        addr_d = {base_pg, 6'b000000, hidx_q};
        unique case (hidx_q)
          2'd0: wd_d = status_b;
          2'd1: wd_d = next_pg;
          2'd2: wd_d = total_len[7:0];
          default: wd_d = total_len[15:8];
        endcase
        hidx_d = hidx_q + 2'd1;
        if (hidx_q == 2'd3) begin
          commit  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_pg   <= '0;
      daddr_q   <= '0;
      byte_cnt  <= '0;
      grp_q     <= 1'b0;
      hidx_q    <= 2'd0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q <= state_d;
      base_pg <= base_d;
      daddr_q <= daddr_d;
      byte_cnt <= cnt_d;
      grp_q   <= grp_d;
      hidx_q  <= hidx_d;
      mem_we  <= we_d;
      if (we_d) begin
        mem_addr  <= addr_d;
        mem_wdata <= wd_d;
      end
    end
  end

  // R2: a refused frame never reaches memory
  a_r2_no_write_in_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |=> !mem_we);
  // R5: every padding cycle produces a zero byte
  a_r5_pad_writes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |=> (mem_we && mem_wdata == 8'h00));
  // R6: writes stay inside the ring (stable, consistent configuration)
  a_r6_addr_below_stop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < {stop_pg, {PAGE_SHIFT{1'b0}}}));
  // R11: no byte is taken while padding or writing the header
  a_r11_stall_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV && beat && rx_eof) |=> !rx_ready);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W       = 8,
  parameter int LEN_W      = 16,
  parameter int MEM_END_PG = 128,
  parameter int MAX_FRAME  = 1514,
  parameter int MIN_FRAME  = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [PG_W-1:0]      cfg_wdata,
  input  logic                 stop_cmd,
  input  logic                 irq_clr,
  input  logic                 rx_valid,
  input  logic                 rx_sof,
  input  logic                 rx_eof,
  input  logic [7:0]           rx_data,
  output logic                 rx_ready,
  output logic                 mem_we,
  output logic [PG_W+7:0]      mem_addr,
  output logic [7:0]           mem_wdata,
  output logic [PG_W-1:0]      cur_page,
  output logic                 irq_rx
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [PG_W-1:0]  start_pg, stop_pg, bnd_pg, base_pg, base_sel, next_pg;
  logic [LEN_W-1:0] byte_cnt;
  logic             room_ok, commit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rxr_regs #(.PG_W(PG_W), .MEM_END_PG(MEM_END_PG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .commit   (commit),
    .next_pg  (next_pg),
    .irq_clr  (irq_clr),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .bnd_pg   (bnd_pg),
    .cur_pg   (cur_page),
    .irq_rx   (irq_rx)
  );

  rxr_ring_math #(.PG_W(PG_W), .LEN_W(LEN_W), .MEM_END_PG(MEM_END_PG),
                  .MAX_FRAME(MAX_FRAME)) u_math (
    .start_pg(start_pg),
    .stop_pg (stop_pg),
    .bnd_pg  (bnd_pg),
    .cur_pg  (cur_page),
    .base_pg (base_pg),
    .byte_cnt(byte_cnt),
    .room_ok (room_ok),
    .base_sel(base_sel),
    .next_pg (next_pg)
  );

  rxr_fsm #(.PG_W(PG_W), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .stop_cmd (stop_cmd),
    .room_ok  (room_ok),
    .base_sel (base_sel),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .next_pg  (next_pg),
    .base_pg  (base_pg),
    .byte_cnt (byte_cnt),
    .commit   (commit),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        stop_cmd, irq_clr;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic        rx_ready, mem_we, irq_rx;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 0;
  bit done    = 0;

  int m_start = 0, m_stop = 0, m_bnd = 0, m_cur = 0;
  bit m_irq = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  frm[$];

  always #2.5 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .stop_cmd(stop_cmd), .irq_clr(irq_clr), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_ready(rx_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_page(cur_page), .irq_rx(irq_rx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    logic [23:0] e;
    if (mon_on && mem_we) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R2 R3 R11 unexpected write", int'({mem_addr, mem_wdata}), 0);
      else begin
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R5 R6 R7 write", int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  task automatic model_frame(output bit acc);
    int avail, size, index, total, nxt, a;
    logic [7:0] b;
    acc = 0;
    if (stop_cmd) return;
    if (m_stop <= m_start) return;
    avail = (m_cur < m_bnd) ? (m_bnd - m_cur) * 256
                            : (m_stop - m_start) * 256 - (m_cur - m_bnd) * 256;
    if (avail < 1518) return;
    acc = 1;
    size  = (frm.size() < 60) ? 60 : frm.size();
    index = (m_cur >= 128) ? m_start * 256 : m_cur * 256;
    total = size + 4;
    nxt   = index + ((total + 4 + 255) / 256) * 256;
    if (nxt >= m_stop * 256) nxt -= (m_stop - m_start) * 256;
    a = index + 4;
    for (int i = 0; i < size; i++) begin
      b = (i < frm.size()) ? frm[i] : 8'h00;
      exp_q.push_back({16'(a), b});
      a++;
      if (a == m_stop * 256) a = m_start * 256;
    end
    exp_q.push_back({16'(index),     (frm[0][0] ? 8'h21 : 8'h01)});
    exp_q.push_back({16'(index + 1), 8'(nxt / 256)});
    exp_q.push_back({16'(index + 2), 8'(total % 256)});
    exp_q.push_back({16'(index + 3), 8'(total / 256)});
    m_cur = nxt / 256;
    m_irq = 1;
  endtask

  task automatic make_frame(input int len, input logic [7:0] first, input int seed);
    frm.delete();
    for (int i = 0; i < len; i++) frm.push_back((i == 0) ? first : 8'((i * 7 + seed) % 251 + 1));
  endtask

  task automatic send(input int gap, input string tag);
    bit acc;
    model_frame(acc);
    @(negedge clk);
    for (int i = 0; i < frm.size(); i++) begin
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == frm.size() - 1);
      rx_data  = frm[i];
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    if (acc) chk(rx_ready == 1'b0, {tag, " R11 stall after last byte"}, int'(rx_ready), 0);
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R6 R7 all writes seen"}, exp_q.size(), 0);
    chk(cur_page == 8'(m_cur), {tag, " R9 current page"}, int'(cur_page), m_cur);
    chk(irq_rx == m_irq, {tag, " R10 irq flag"}, int'(irq_rx), int'(m_irq));
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: if (val <= 128) m_start = val;
      2'd1: if (val <= 128) m_stop  = val;
      2'd2: if (val < 128)  m_bnd   = val;
      default: if (val < 128) m_cur = val;
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; stop_cmd = 0; irq_clr = 0;
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
    repeat (4) @(negedge clk);
    chk(rx_ready == 1'b1, "R1 ready in reset", int'(rx_ready), 1);
    chk(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;
    chk(cur_page == 8'h00, "R1 current page after reset", int'(cur_page), 0);
    chk(irq_rx == 1'b0, "R1 irq after reset", int'(irq_rx), 0);

    // R3: all ring pages zero, so stop <= start
    make_frame(64, 8'h02, 1); send(0, "R3 zero ring");

    cfg(2'd0, 8'h40); cfg(2'd1, 8'h60); cfg(2'd2, 8'h40); cfg(2'd3, 8'h40);
    chk(cur_page == 8'h40, "R12 current write", int'(cur_page), 8'h40);
    cfg(2'd3, 8'h90);
    @(negedge clk);
    chk(cur_page == 8'h40, "R12 out of range current ignored", int'(cur_page), 8'h40);
    cfg(2'd0, 8'h81);   // ignored: start stays 0x40

    make_frame(64, 8'h02, 3);  send(0, "R8 unicast 64");
    make_frame(20, 8'h01, 5);  send(0, "R5 R8 group short");

    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; m_irq = 0;
    @(negedge clk);
    chk(irq_rx == 1'b0, "R10 irq cleared", int'(irq_rx), 0);

    stop_cmd = 1'b1;
    make_frame(70, 8'h02, 7); send(0, "R2 stopped");
    stop_cmd = 1'b0;

    // R11: stray byte without start marker
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h5a;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cur_page == 8'(m_cur), "R11 stray byte ignored", int'(cur_page), m_cur);

    make_frame(60, 8'h04, 9);  send(2, "R5 exact 60 with gaps");
    make_frame(1, 8'h03, 11);  send(0, "R5 single byte");

    // R6 R9: wrap across the stop page
    cfg(2'd2, 8'h58); cfg(2'd3, 8'h5f);
    make_frame(300, 8'h01, 13); send(0, "R6 R9 wrap");

    // R4: room threshold around 1518 bytes with current 0x41
    cfg(2'd2, 8'h46);
    make_frame(100, 8'h02, 15); send(0, "R4 five pages refused");
    cfg(2'd2, 8'h47);
    make_frame(100, 8'h02, 17); send(1, "R4 six pages accepted");

    cfg(2'd1, 8'h40);
    make_frame(80, 8'h02, 19); send(0, "R3 stop equals start");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule